// File: doc/BRIEF.md
# Horizontal Blanking Toggle Generator

This block produces the horizontal blanking level of a line-scanned sensor timing chain. A shared pixel counter runs through each line. At the positions held in up to six toggle-position inputs, the block inverts its blanking output. A horizontal sync pulse starts each line and forces the output back to its inactive (low) level. The same pulse re-arms the toggle sequence.

An alternation enable lets odd and even lines use different toggle sets. With alternation on, odd lines use positions 1 and 2, which gives one blanking pulse. Even lines use positions 3 to 6, which gives up to two pulses. With alternation off, every line uses positions 1 and 2. This alternation is independent of any vertical-clock repeat alternation elsewhere in the timing chain. The two can be used separately or together.

All inputs are plain control levels and there is no data stream, so no valid/ready handshake is used. The line parity and the alternation enable are sampled on the sync cycle. The toggle positions are read live.

Top module: `hblank_toggle_gen`

## Requirements
- R1: After reset `hblank` is 0, and it stays 0 until the first `hsync`, whatever the pixel counter shows.
- R2: A cycle with `hsync` high makes `hblank` 0 on the following cycle. The pixel count on that cycle is not compared.
- R3: When the pending toggle position equals `pix_cnt`, `hblank` inverts at that clock edge. The new level is visible in the cycle after the match.
- R4: Positions are compared one at a time, in ascending order within the selected set. Only the pending position can match, so a later position whose pixel has already gone by never fires.
- R5: With `alt_en` = 0, every line uses positions 1 and 2 only.
- R6: With `alt_en` = 1 and `line_odd` = 1, the line uses positions 1 and 2 only.
- R7: With `alt_en` = 1 and `line_odd` = 0, the line uses positions 3, 4, 5 and 6, in that order. This gives up to two blanking pulses.
- R8: A position field of all ones (12'hFFF at default width) never matches. It therefore also stops every later position of that set on that line.
- R9: `alt_en` and `line_odd` are sampled only on the `hsync` cycle. Changing them later in the line does not alter the set in use.
- R10: After the last position of the selected set has toggled, `hblank` holds until the next `hsync`.
- R11: Position k (1 to 6) occupies bits `tog_pos[(k-1)*PIX_W +: PIX_W]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync | input | 1 | Line start pulse, one cycle high |
| pix_cnt | input | PIX_W (12) | Pixel position counted from sync |
| line_odd | input | 1 | 1 on odd lines, sampled at sync |
| alt_en | input | 1 | Odd/even toggle-set alternation enable, sampled at sync |
| tog_pos | input | NUM_TOG*PIX_W (72) | Six packed toggle positions, position 1 in the low bits |
| hblank | output | 1 | Horizontal blanking level, 1 = blanking |

## Verification
Each line runs the pixel counter from 0 to 31 and records the blanking level after every pixel as a 32-bit waveform. That waveform is compared against an expected mask. The table covers the following cases:
- The alternation-off, odd-alt and even-alt cases on identical positions, which separates the three set selections.
- A descending pair, which tells ordered comparison from any-match.
- All-ones entries at the start and in the middle of a set.
- Adjacent even-line positions and the extreme pixels 0 and 31.

Directed tests cover the pre-sync idle period, a sync arriving mid-pulse, and a parity/enable change after sync.

// File: rtl/hbt_pkg.sv
package hbt_pkg;

  typedef enum logic {
    SET_BASE = 1'b0,
    SET_ALT  = 1'b1
  } tog_set_e;

  function automatic tog_set_e pick_set(input logic alt, input logic odd);
    return (alt && !odd) ? SET_ALT : SET_BASE;
  endfunction

endpackage

// File: rtl/hbt_set_sel.sv
module hbt_set_sel
  import hbt_pkg::*;
#(
  parameter int NUM_TOG  = 6,
  parameter int BASE_CNT = 2,
  parameter int IDX_W    = 3
) (
  input  logic             alt_en,
  input  logic             line_odd,
  output logic [IDX_W-1:0] first_idx,
  output logic [IDX_W-1:0] last_idx
);

  localparam logic [IDX_W-1:0] BASE_FIRST = '0;
  localparam logic [IDX_W-1:0] BASE_LAST  = IDX_W'(BASE_CNT - 1);
  localparam logic [IDX_W-1:0] ALT_FIRST  = IDX_W'(BASE_CNT);
  localparam logic [IDX_W-1:0] ALT_LAST   = IDX_W'(NUM_TOG - 1);

  tog_set_e set_sel;

  always_comb begin
    set_sel = pick_set(alt_en, line_odd);
    if (set_sel == SET_ALT) begin
      first_idx = ALT_FIRST;
      last_idx  = ALT_LAST;
    end else begin
      first_idx = BASE_FIRST;
      last_idx  = BASE_LAST;
    end
  end

endmodule

// File: rtl/hbt_cmp.sv
module hbt_cmp #(
  parameter int PIX_W   = 12,
  parameter int NUM_TOG = 6,
  parameter int IDX_W   = 3
) (
  input  logic [NUM_TOG*PIX_W-1:0] tog_pos,
  input  logic [PIX_W-1:0]         pix_cnt,
  input  logic [IDX_W-1:0]         idx,
  output logic                     hit
);

  localparam int SLOTS = 1 << IDX_W;

  logic [SLOTS-1:0] eq;

  genvar k;
  generate
    for (k = 0; k < SLOTS; k++) begin : g_slot
      if (k < NUM_TOG) begin : g_live
        logic [PIX_W-1:0] pos;
        assign pos   = tog_pos[k*PIX_W +: PIX_W];
        assign eq[k] = (pos == pix_cnt) && (pos != {PIX_W{1'b1}});
      end else begin : g_pad
        assign eq[k] = 1'b0;
      end
    end
  endgenerate

  assign hit = eq[idx];

endmodule

// File: rtl/hbt_seq.sv
module hbt_seq #(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsync,
  input  logic [IDX_W-1:0] first_idx,
  input  logic [IDX_W-1:0] last_idx,
  input  logic             hit,
  output logic [IDX_W-1:0] idx,
  output logic             level
);

  logic [IDX_W-1:0] last_q;
  logic             armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level   <= 1'b0;
      idx     <= '0;
      last_q  <= '0;
      armed_q <= 1'b0;
    end else if (hsync) begin
      level   <= 1'b0;
      idx     <= first_idx;
      last_q  <= last_idx;
      armed_q <= 1'b1;
    end else if (armed_q && hit) begin
      level <= ~level;
      if (idx == last_q) armed_q <= 1'b0;
      else               idx     <= idx + IDX_W'(1);
    end
  end

endmodule

// File: rtl/hblank_toggle_gen.sv
module hblank_toggle_gen #(
  parameter int PIX_W    = 12,
  parameter int NUM_TOG  = 6,
  parameter int BASE_CNT = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     hsync,
  input  logic [PIX_W-1:0]         pix_cnt,
  input  logic                     line_odd,
  input  logic                     alt_en,
  input  logic [NUM_TOG*PIX_W-1:0] tog_pos,
  output logic                     hblank
);

  localparam int IDX_W = $clog2(NUM_TOG);

  logic [IDX_W-1:0] first_idx, last_idx, idx;
  logic             hit;

  hbt_set_sel #(.NUM_TOG(NUM_TOG), .BASE_CNT(BASE_CNT), .IDX_W(IDX_W)) u_sel (
    .alt_en    (alt_en),
    .line_odd  (line_odd),
    .first_idx (first_idx),
    .last_idx  (last_idx)
  );

  hbt_cmp #(.PIX_W(PIX_W), .NUM_TOG(NUM_TOG), .IDX_W(IDX_W)) u_cmp (
    .tog_pos (tog_pos),
    .pix_cnt (pix_cnt),
    .idx     (idx),
    .hit     (hit)
  );

  hbt_seq #(.IDX_W(IDX_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .hsync     (hsync),
    .first_idx (first_idx),
    .last_idx  (last_idx),
    .hit       (hit),
    .idx       (idx),
    .level     (hblank)
  );

endmodule

// File: rtl/hblank_toggle_gen_chk.sv
module hblank_toggle_gen_chk #(
  parameter int PIX_W    = 12,
  parameter int NUM_TOG  = 6,
  parameter int BASE_CNT = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hsync,
  input logic [PIX_W-1:0] pix_cnt,
  input logic             line_odd,
  input logic             alt_en,
  input logic             hblank
);

  localparam logic [3:0] LIM_BASE = 4'(BASE_CNT);
  localparam logic [3:0] LIM_ALT  = 4'(NUM_TOG - BASE_CNT);

  logic       seen_q, hb_prev, hs_prev;
  logic [3:0] cnt_q, lim_q;
  logic       chg;

  assign chg = (hblank != hb_prev) && !hs_prev && seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q  <= 1'b0;
      hb_prev <= 1'b0;
      hs_prev <= 1'b0;
      cnt_q   <= '0;
      lim_q   <= '0;
    end else begin
      hb_prev <= hblank;
      hs_prev <= hsync;
      if (hsync) begin
        seen_q <= 1'b1;
        cnt_q  <= '0;
        lim_q  <= (alt_en && !line_odd) ? LIM_ALT : LIM_BASE;
      end else if (chg && cnt_q != 4'hF) begin
        cnt_q <= cnt_q + 4'd1;
      end
    end
  end

  // R1
  pre_sync_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> !hblank);

  // R2
  sync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hsync |=> !hblank);

  // R8
  ones_nomatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hsync && (&pix_cnt)) |=> $stable(hblank));

  // R5 R6 R7 R10
  toggle_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lim_q);

endmodule

bind hblank_toggle_gen hblank_toggle_gen_chk #(
  .PIX_W(PIX_W), .NUM_TOG(NUM_TOG), .BASE_CNT(BASE_CNT)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .hsync    (hsync),
  .pix_cnt  (pix_cnt),
  .line_odd (line_odd),
  .alt_en   (alt_en),
  .hblank   (hblank)
);

// File: tb/sim_hblank_toggle_gen.sv
module sim_hblank_toggle_gen;

  localparam int CLK_PERIOD = 10;
  localparam int PIX_W      = 12;
  localparam int NUM_TOG    = 6;
  localparam logic [11:0] U = 12'hFFF;

  typedef struct packed {
    logic                     alt;
    logic                     odd;
    logic [NUM_TOG*PIX_W-1:0] pos;
    logic [31:0]              wave;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 1'b0, {12'd30, 12'd25, 12'd20, 12'd15, 12'd10, 12'd4}, 32'h000003F0},
    '{1'b1, 1'b1, {12'd25, 12'd20, 12'd12, 12'd10, 12'd6,  12'd2}, 32'h0000003C},
    '{1'b1, 1'b0, {12'd25, 12'd20, 12'd12, 12'd10, 12'd6,  12'd2}, 32'h01F00C00},
    '{1'b1, 1'b0, {12'd28, U,      12'd18, 12'd8,  12'd6,  12'd2}, 32'h0003FF00},
    '{1'b0, 1'b0, {U,      U,      U,      U,      12'd5,  12'd20}, 32'hFFF00000},
    '{1'b0, 1'b0, {U,      U,      U,      U,      12'd3,  U},      32'h00000000},
    '{1'b1, 1'b0, {12'd6,  12'd5,  12'd4,  12'd3,  U,      U},      32'h00000028},
    '{1'b0, 1'b0, {U,      U,      U,      U,      12'd31, 12'd0},  32'h7FFFFFFF}
  };

  function automatic string tag_of(input int i);
    case (i)
      0: return "R5 R10 R11";
      1: return "R6";
      2: return "R7";
      3: return "R8 mid-set";
      4: return "R4";
      5: return "R8 first";
      6: return "R7 adjacent";
      default: return "R3 edges";
    endcase
  endfunction

  logic clk = 1'b0, rst_n = 1'b0, hsync = 1'b0, line_odd = 1'b0, alt_en = 1'b0;
  logic [PIX_W-1:0] pix_cnt = '0;
  logic [NUM_TOG*PIX_W-1:0] tog_pos = '1;
  logic hblank;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hblank_toggle_gen u0 (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .pix_cnt(pix_cnt),
    .line_odd(line_odd), .alt_en(alt_en), .tog_pos(tog_pos), .hblank(hblank)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_line(input logic a_s, input logic o_s, input logic a_m,
                          input logic o_m, output logic [31:0] wave);
    @(negedge clk); hsync = 1'b1; alt_en = a_s; line_odd = o_s; pix_cnt = '0;
    @(negedge clk); hsync = 1'b0; alt_en = a_m; line_odd = o_m;
    for (int p = 0; p < 32; p++) begin
      @(negedge clk);
      wave[p]  = hblank;
      pix_cnt  = PIX_W'(p + 1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] w;
    logic        seen;
    repeat (2) @(negedge clk);
    check({31'd0, hblank}, 32'd0, "R1 reset level");
    rst_n = 1'b1;
    // R1: positions loaded, but no sync yet
    tog_pos = {U, U, U, U, 12'd5, 12'd3};
    seen = 1'b0;
    for (int p = 0; p < 8; p++) begin
      @(negedge clk); pix_cnt = PIX_W'(p);
      seen = seen | hblank;
    end
    @(negedge clk); seen = seen | hblank;
    check({31'd0, seen}, 32'd0, "R1 idle before sync");

    for (int i = 0; i < NV; i++) begin
      tog_pos = TBL[i].pos;
      run_line(TBL[i].alt, TBL[i].odd, TBL[i].alt, TBL[i].odd, w);
      check(w, TBL[i].wave, tag_of(i));
    end

    // R2: sync arriving during a blanking pulse
    tog_pos = {U, U, U, U, 12'd10, 12'd4};
    @(negedge clk); hsync = 1'b1; alt_en = 1'b0; pix_cnt = '0;
    @(negedge clk); hsync = 1'b0;
    for (int p = 0; p < 7; p++) begin
      @(negedge clk); pix_cnt = PIX_W'(p + 1);
    end
    check({31'd0, hblank}, 32'd1, "R2 pulse active before sync");
    hsync = 1'b1; pix_cnt = 12'd4;
    @(negedge clk); hsync = 1'b0; pix_cnt = 12'd5;
    check({31'd0, hblank}, 32'd0, "R2 sync clears level");

    // R9: parity/enable change after sync keeps even set
    tog_pos = {U, U, 12'd12, 12'd10, 12'd6, 12'd2};
    run_line(1'b1, 1'b0, 1'b0, 1'b1, w);
    check(w, 32'h00000C00, "R9 sampled at sync");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule